// File: doc/BRIEF.md
# External Bus Read Timing Sequencer

This block turns read requests from an on-chip requester into timed read cycles on a parallel external memory bus. Each access walks through three phases whose lengths are programmable: an address setup phase, a strobe phase with output enable active, and a hold phase. The address stays on the bus for the whole access. Chip select is active from the first setup cycle through the last hold cycle. Read data is sampled from the external data lines in the last strobe cycle and handed back with a one-cycle done pulse.

The requester raises a request together with an address and keeps it up until the block acknowledges it with a one-cycle accept pulse. The setup, strobe and hold counts and the idle-suppression bit are taken at the moment of acceptance. A configuration change therefore applies only to later accesses. With idle suppression off, the bus returns to an idle cycle after every read. With it on, a waiting request is taken in the last cycle of the current access, and the next setup follows with no gap. Only the last read of such a chain is followed by an idle cycle.

Top module: `ext_rd_seq`

## Requirements
- R1: After reset, with no request, chip select and output enable are both high (inactive), and done and accept are low.
- R2: The setup phase lasts exactly the programmed setup count of cycles (zero allowed). It begins in the cycle after the accept pulse, with chip select low and output enable high.
- R3: The strobe phase follows setup and lasts the programmed strobe count of cycles, where a count of 0 acts as 1. Output enable is low in exactly these cycles.
- R4: The hold phase follows strobe and lasts the programmed hold count of cycles (zero allowed), with chip select low and output enable high.
- R5: The data lines are sampled in the last strobe cycle. In the following cycle, done is high for one cycle and the read-data output shows the sampled value. That value stays until the next capture.
- R6: The address output equals the accepted address in every setup, strobe and hold cycle of the access. It changes only when a new access starts.
- R7: With the idle-suppression bit clear at acceptance, every access is followed by one cycle with chip select high. A request already waiting is accepted in that cycle.
- R8: With the idle-suppression bit set at acceptance, a waiting request is accepted in the last cycle of the access (last hold cycle, or last strobe cycle when hold is 0). Chip select stays low into the next setup. After the final access of the chain, chip select goes high.
- R9: Setup, strobe and hold counts and the idle-suppression bit are used as they were in the accept cycle. Changing them later does not alter the running access.
- R10: Accept pulses only in an idle cycle or in the last cycle of an access with idle suppression. It is never high in any other cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, held until accepted |
| req_addr_i | input | ADDR_W | Address of the requested read |
| setup_cfg_i | input | CNT_W | Setup phase length in cycles |
| strobe_cfg_i | input | CNT_W | Strobe phase length in cycles (0 acts as 1) |
| hold_cfg_i | input | CNT_W | Hold phase length in cycles |
| no_idle_i | input | 1 | Idle-suppression bit |
| req_accept_o | output | 1 | One-cycle pulse when the request is taken |
| bus_addr_o | output | ADDR_W | Address on the external bus |
| bus_cs_n_o | output | 1 | Active-low chip select |
| bus_oe_n_o | output | 1 | Active-low output enable |
| bus_data_i | input | DATA_W | External data lines |
| rd_data_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle pulse with new read data |

## Verification
The assertions assume the requester keeps `req_i` and `req_addr_i` steady from raising the request until it sees the accept pulse. They also assume configuration inputs settle before the accept cycle. The address-steadiness and chip-select properties depend on acceptance being the only way a new access starts. The bench changes its inputs only on the falling edge. It loads the address and counts for the next access just after each accept edge, so every request is presented in a legal way. It also loads junk into the counts and address once the last access of a burst has been taken, to show they are ignored.

// File: rtl/ext_rd_seq_pkg.sv
package ext_rd_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

endpackage

// File: rtl/ext_rd_seq_ctrl.sv
module ext_rd_seq_ctrl
   import ext_rd_seq_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [CNT_W-1:0] setup_cfg_i,
   input  logic [CNT_W-1:0] strobe_cfg_i,
   input  logic [CNT_W-1:0] hold_cfg_i,
   input  logic             no_idle_i,
   output phase_e           phase_o,
   output logic             accept_o,
   output logic             last_strobe_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] strobe_q, hold_q;
   logic             nidle_q;
   logic             cnt_last;
   logic             access_end;

   function automatic logic [CNT_W-1:0] strobe_load(input logic [CNT_W-1:0] n);
      return (n == CNT_ZERO) ? CNT_ZERO : n - CNT_ONE;
   endfunction

   assign cnt_last      = (cnt_q == CNT_ZERO);
   assign last_strobe_o = (phase_q == PH_STROBE) && cnt_last;
   assign access_end    = ((phase_q == PH_HOLD) && cnt_last) ||
                          (last_strobe_o && (hold_q == CNT_ZERO));
   assign accept_o      = req_i && ((phase_q == PH_IDLE) || (access_end && nidle_q));
   assign phase_o       = phase_q;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      if (accept_o) begin
         if (setup_cfg_i != CNT_ZERO) begin
            phase_d = PH_SETUP;
            cnt_d   = setup_cfg_i - CNT_ONE;
         end else begin
            phase_d = PH_STROBE;
            cnt_d   = strobe_load(strobe_cfg_i);
         end
      end else begin
         unique case (phase_q)
            PH_SETUP: begin
               if (cnt_last) begin
                  phase_d = PH_STROBE;
                  cnt_d   = strobe_load(strobe_q);
               end else begin
                  cnt_d = cnt_q - CNT_ONE;
               end
            end
            PH_STROBE: begin
               if (!cnt_last) begin
                  cnt_d = cnt_q - CNT_ONE;
               end else if (hold_q != CNT_ZERO) begin
                  phase_d = PH_HOLD;
                  cnt_d   = hold_q - CNT_ONE;
               end else begin
                  phase_d = PH_IDLE;
               end
            end
            PH_HOLD: begin
               if (cnt_last) phase_d = PH_IDLE;
               else          cnt_d   = cnt_q - CNT_ONE;
            end
            default: phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= CNT_ZERO;
         strobe_q <= CNT_ZERO;
         hold_q   <= CNT_ZERO;
         nidle_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         if (accept_o) begin
            strobe_q <= strobe_cfg_i;
            hold_q   <= hold_cfg_i;
            nidle_q  <= no_idle_i;
         end
      end
   end

   // R2: a setup phase never outlasts its loaded length (counter only counts down)
   a_r2_setup_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SETUP && $past(phase_q) == PH_SETUP && !$past(accept_o))
         |-> (cnt_q == $past(cnt_q) - CNT_ONE));

   // R7: back-to-back accesses without an idle cycle only when suppression was latched
   a_r7_gap_unless_chained: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(accept_o) && $past(phase_q) != PH_IDLE) |-> $past(nidle_q));

endmodule

// File: rtl/ext_rd_seq_addr.sv
module ext_rd_seq_addr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= addr_i;
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/ext_rd_seq_capture.sv
module ext_rd_seq_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_i,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o
);

   logic [DATA_W-1:0] data_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= sample_i;
         if (sample_i) data_q <= bus_data_i;
      end
   end

   assign data_o = data_q;
   assign done_o = done_q;

   // R5: data only changes together with a done pulse
   a_r5_data_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(data_o));

endmodule

// File: rtl/ext_rd_seq.sv
module ext_rd_seq
   import ext_rd_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [CNT_W-1:0]  setup_cfg_i,
   input  logic [CNT_W-1:0]  strobe_cfg_i,
   input  logic [CNT_W-1:0]  hold_cfg_i,
   input  logic              no_idle_i,
   output logic              req_accept_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_cs_n_o,
   output logic              bus_oe_n_o,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              done_o
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("ext_rd_seq: ADDR_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("ext_rd_seq: DATA_W must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("ext_rd_seq: CNT_W must lie in 1..16");
      end
   endgenerate

   phase_e phase;
   logic   accept;
   logic   last_strobe;

   ext_rd_seq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req_i),
      .setup_cfg_i   (setup_cfg_i),
      .strobe_cfg_i  (strobe_cfg_i),
      .hold_cfg_i    (hold_cfg_i),
      .no_idle_i     (no_idle_i),
      .phase_o       (phase),
      .accept_o      (accept),
      .last_strobe_o (last_strobe)
   );

   ext_rd_seq_addr #(.ADDR_W(ADDR_W)) i_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .addr_i (req_addr_i),
      .addr_o (bus_addr_o)
   );

   ext_rd_seq_capture #(.DATA_W(DATA_W)) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_i   (last_strobe),
      .bus_data_i (bus_data_i),
      .data_o     (rd_data_o),
      .done_o     (done_o)
   );

   assign req_accept_o = accept;
   assign bus_cs_n_o   = (phase == PH_IDLE);
   assign bus_oe_n_o   = (phase != PH_STROBE);

   // R3: output enable is only ever active inside chip select
   a_r3_oe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_n_o |-> !bus_cs_n_o);

   // R6: address stays put within an access unless a new one was taken
   a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n_o && $past(!bus_cs_n_o) && !$past(req_accept_o)) |-> $stable(bus_addr_o));

   // R5: done follows a cycle with output enable active
   a_r5_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(!bus_oe_n_o));

   // R10: chip select only falls after an accept pulse
   a_r10_cs_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n_o && $past(bus_cs_n_o)) |-> $past(req_accept_o));

endmodule

// File: tb/test_ext_rd_seq.sv
module test_ext_rd_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [AW-1:0] req_addr_i = '0;
   logic [CW-1:0] setup_cfg_i = '0;
   logic [CW-1:0] strobe_cfg_i = '0;
   logic [CW-1:0] hold_cfg_i = '0;
   logic          no_idle_i = 1'b0;
   logic          req_accept_o;
   logic [AW-1:0] bus_addr_o;
   logic          bus_cs_n_o;
   logic          bus_oe_n_o;
   logic [DW-1:0] bus_data_i = '0;
   logic [DW-1:0] rd_data_o;
   logic          done_o;

   int n_checks = 0;
   int n_fails  = 0;

   int            s_a [4];
   int            t_a [4];
   int            h_a [4];
   logic [AW-1:0] a_a [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_rd_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_ext_rd_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .req_addr_i   (req_addr_i),
      .setup_cfg_i  (setup_cfg_i),
      .strobe_cfg_i (strobe_cfg_i),
      .hold_cfg_i   (hold_cfg_i),
      .no_idle_i    (no_idle_i),
      .req_accept_o (req_accept_o),
      .bus_addr_o   (bus_addr_o),
      .bus_cs_n_o   (bus_cs_n_o),
      .bus_oe_n_o   (bus_oe_n_o),
      .bus_data_i   (bus_data_i),
      .rd_data_o    (rd_data_o),
      .done_o       (done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int k);
      return a_a[k] ^ 16'h5A3C;
   endfunction

   task automatic load_cfg(input int k);
      req_addr_i   = a_a[k];
      setup_cfg_i  = CW'(s_a[k]);
      strobe_cfg_i = CW'(t_a[k]);
      hold_cfg_i   = CW'(h_a[k]);
   endtask

   // runs n accesses; inputs change only on the falling edge
   task automatic run_burst(input int n, input bit ni);
      bit chained_prev = 1'b0;
      no_idle_i = ni;
      req_i = 1'b1;
      load_cfg(0);
      for (int k = 0; k < n; k++) begin
         int te;
         int tot;
         bit chain;
         te    = (t_a[k] == 0) ? 1 : t_a[k];
         tot   = s_a[k] + te + h_a[k];
         chain = ni && (k + 1 < n);
         if (!chained_prev) begin
            #1;
            chk(req_accept_o == 1'b1, "R7", "accept in idle cycle", 32'(req_accept_o), 1);
            chk(bus_cs_n_o == 1'b1, "R7", "cs high in idle cycle", 32'(bus_cs_n_o), 1);
            @(negedge clk);
         end
         // R9: next access's settings (or junk) applied after acceptance
         if (k + 1 < n) begin
            load_cfg(k + 1);
         end else begin
            req_i        = 1'b0;
            req_addr_i   = 16'hDEAD;
            setup_cfg_i  = 4'd9;
            strobe_cfg_i = 4'd9;
            hold_cfg_i   = 4'd9;
            no_idle_i    = ~ni;
         end
         for (int j = 0; j < tot; j++) begin
            bit in_strobe;
            in_strobe  = (j >= s_a[k]) && (j < s_a[k] + te);
            bus_data_i = (j == s_a[k] + te - 1) ? pat(k) : ~pat(k);
            #1;
            chk(bus_cs_n_o == 1'b0, (j < s_a[k]) ? "R2" : (in_strobe ? "R3" : "R4"),
                "cs low in access", 32'(bus_cs_n_o), 0);
            chk(bus_oe_n_o == !in_strobe, in_strobe ? "R3" : "R4",
                "oe level", 32'(bus_oe_n_o), 32'(!in_strobe));
            chk(bus_addr_o == a_a[k], "R6", "address held", 32'(bus_addr_o), 32'(a_a[k]));
            if (j > 0) begin
               chk(done_o == (j == s_a[k] + te), "R5", "done timing",
                   32'(done_o), 32'(j == s_a[k] + te));
               if (j == s_a[k] + te)
                  chk(rd_data_o == pat(k), "R5", "read data", 32'(rd_data_o), 32'(pat(k)));
            end
            chk(req_accept_o == (chain && j == tot - 1), chain ? "R8" : "R10",
                "accept point", 32'(req_accept_o), 32'(chain && j == tot - 1));
            if (j < tot - 1) @(negedge clk);
         end
         @(negedge clk);
         #1;
         if (h_a[k] == 0) begin
            chk(done_o == 1'b1, "R5", "done after strobe (no hold)", 32'(done_o), 1);
            chk(rd_data_o == pat(k), "R5", "read data (no hold)", 32'(rd_data_o), 32'(pat(k)));
         end
         if (!chain)
            chk(bus_cs_n_o == 1'b1, ni ? "R8" : "R7", "cs high after access",
                32'(bus_cs_n_o), 1);
         chained_prev = chain;
      end
      if (n > 0 && h_a[n-1] > 0) begin
         chk(done_o == 1'b0, "R5", "done one cycle", 32'(done_o), 0);
      end
      chk(rd_data_o == pat(n-1), "R5", "data held", 32'(rd_data_o), 32'(pat(n-1)));
      chk(req_accept_o == 1'b0, "R10", "no accept without request", 32'(req_accept_o), 0);
   endtask

   task automatic t_reset();
      #1;
      chk(bus_cs_n_o == 1'b1, "R1", "cs after reset", 32'(bus_cs_n_o), 1);
      chk(bus_oe_n_o == 1'b1, "R1", "oe after reset", 32'(bus_oe_n_o), 1);
      chk(done_o == 1'b0, "R1", "done after reset", 32'(done_o), 0);
      chk(req_accept_o == 1'b0, "R1", "accept after reset", 32'(req_accept_o), 0);
   endtask

   task automatic t_single();
      s_a[0] = 2; t_a[0] = 3; h_a[0] = 1; a_a[0] = 16'h1234;
      run_burst(1, 1'b0);
   endtask

   task automatic t_minimal();
      s_a[0] = 0; t_a[0] = 1; h_a[0] = 0; a_a[0] = 16'h00F1;
      run_burst(1, 1'b1);
   endtask

   task automatic t_strobe_zero();
      s_a[0] = 1; t_a[0] = 0; h_a[0] = 2; a_a[0] = 16'hBEEF;
      run_burst(1, 1'b0);
   endtask

   task automatic t_burst_idle();
      s_a[0] = 1; t_a[0] = 2; h_a[0] = 1; a_a[0] = 16'h0100;
      s_a[1] = 0; t_a[1] = 1; h_a[1] = 0; a_a[1] = 16'h0102;
      s_a[2] = 3; t_a[2] = 4; h_a[2] = 2; a_a[2] = 16'h0104;
      run_burst(3, 1'b0);
   endtask

   task automatic t_burst_noidle();
      s_a[0] = 2; t_a[0] = 1; h_a[0] = 2; a_a[0] = 16'h2000;
      s_a[1] = 0; t_a[1] = 2; h_a[1] = 0; a_a[1] = 16'h2002;
      s_a[2] = 0; t_a[2] = 1; h_a[2] = 0; a_a[2] = 16'h2004;
      s_a[3] = 1; t_a[3] = 3; h_a[3] = 1; a_a[3] = 16'h2006;
      run_burst(4, 1'b1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      @(negedge clk);
      t_minimal();
      @(negedge clk);
      t_strobe_zero();
      @(negedge clk);
      t_burst_idle();
      @(negedge clk);
      t_burst_noidle();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule